// File: doc/BRIEF.md
# Four-Register Processor Core

This block executes one instruction per clock on four general registers and a program counter. Each instruction arrives as separate fields: a two-bit opcode, a one-bit modifier, a destination register select, a source register select and an address/operand field. The opcode and modifier together choose one of eight actions: load from memory, store to memory, register copy, register complement, add, subtract, unconditional jump and jump on an external condition input.

The core drives a data-memory port. The memory address is always the address field. Read data must come back combinationally in the same cycle. Write data is the source register, and a write strobe goes high only while a store is applied. Instruction fetch is not part of the block. An outside agent presents the fields each cycle and may use the program counter output to find the next instruction. Memory and branch instructions occupy two words, so they move the counter by two. Register instructions occupy one word and move it by one.

Top module: `qrp_core`

## Requirements
- R1: With opcode 0 and modifier 0, the register selected by the destination field is loaded with the memory read data at address = address field, and the counter advances by 2.
- R2: With opcode 0 and modifier 1, the store strobe is high in that cycle. Write data equals the register selected by the source field and the memory address equals the address field. The counter advances by 2 and no register changes.
- R3: With opcode 1, the destination register receives the source register (modifier 0) or its bitwise complement (modifier 1), and the counter advances by 1.
- R4: With opcode 2, the destination register receives destination plus source (modifier 0) or destination minus source (modifier 1), wrapping modulo 2^8, and the counter advances by 1.
- R5: With opcode 3 and modifier 0, the counter is loaded with the address field.
- R6: With opcode 3 and modifier 1, the counter is loaded with the address field when the condition input is 1. Otherwise it advances by 2.
- R7: An active-low reset clears the counter and all four registers to zero.
- R8: Register selects are 2-bit indices 0..3. Any destination/source pair works, including equal ones; for example opcode 2, modifier 0, destination 3, source 2 gives R3 = R3 + R2.
- R9: The store strobe is low for every instruction other than a store. The counter wraps modulo 2^8 on every advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Opcode field |
| mod_i | input | 1 | Modifier field |
| dst_i | input | 2 | Destination register select |
| src_i | input | 2 | Source register select |
| fld_i | input | 8 | Address / jump target field |
| cond_i | input | 1 | Branch condition |
| mem_rdata_i | input | 8 | Memory read data, combinational from mem_addr_o |
| mem_addr_o | output | 8 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| pc_o | output | 8 | Program counter |

## Verification
The registers have no port of their own, so every arithmetic result is only seen by following it with a store that routes it to the write-data bus. The bench pairs each register operation with a store of the affected register. Counter wraparound needs the counter near the top of its range, so the bench first jumps to 0xFF or 0xFE and then issues a one-word or two-word instruction. Carry and borrow wrap are reached by building a register that holds the complement of another, adding the two to get 0xFF, then adding again.

// File: rtl/qrp_pkg.sv
package qrp_pkg;

   typedef enum logic [1:0] {
      OPC_MEM    = 2'd0,
      OPC_MOVE   = 2'd1,
      OPC_ARITH  = 2'd2,
      OPC_BRANCH = 2'd3
   } opc_e;

   typedef enum logic [2:0] {
      FN_MEMRD = 3'd0,
      FN_COPY  = 3'd1,
      FN_INV   = 3'd2,
      FN_ADD   = 3'd3,
      FN_SUB   = 3'd4
   } alu_fn_e;

   typedef enum logic [1:0] {
      PCS_STEP1 = 2'd0,
      PCS_STEP2 = 2'd1,
      PCS_LOAD  = 2'd2
   } pc_sel_e;

   typedef struct packed {
      alu_fn_e fn;
      logic    rf_we;
      logic    mem_we;
      pc_sel_e pc_sel;
   } ctrl_t;

endpackage

// File: rtl/qrp_decode.sv
module qrp_decode
   import qrp_pkg::*;
(
   input  logic [1:0] op_i,
   input  logic       mod_i,
   input  logic       cond_i,
   output ctrl_t      ctrl_o
);

   opc_e opc;
   assign opc = opc_e'(op_i);

   always_comb begin
      ctrl_o.fn     = FN_COPY;
      ctrl_o.rf_we  = 1'b0;
      ctrl_o.mem_we = 1'b0;
      ctrl_o.pc_sel = PCS_STEP1;
      case (opc)
         OPC_MEM: begin
            ctrl_o.fn     = FN_MEMRD;
            ctrl_o.rf_we  = ~mod_i;
            ctrl_o.mem_we = mod_i;
            ctrl_o.pc_sel = PCS_STEP2;
         end
         OPC_MOVE: begin
            ctrl_o.fn     = mod_i ? FN_INV : FN_COPY;
            ctrl_o.rf_we  = 1'b1;
            ctrl_o.pc_sel = PCS_STEP1;
         end
         OPC_ARITH: begin
            ctrl_o.fn     = mod_i ? FN_SUB : FN_ADD;
            ctrl_o.rf_we  = 1'b1;
            ctrl_o.pc_sel = PCS_STEP1;
         end
         OPC_BRANCH: begin
            ctrl_o.pc_sel = (!mod_i || cond_i) ? PCS_LOAD : PCS_STEP2;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/qrp_regfile.sv
module qrp_regfile #(
   parameter int DW   = 8,
   parameter int SELW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic [SELW-1:0] wsel_i,
   input  logic [DW-1:0]   wdata_i,
   input  logic [SELW-1:0] rsel_a_i,
   input  logic [SELW-1:0] rsel_b_i,
   output logic [DW-1:0]   rdata_a_o,
   output logic [DW-1:0]   rdata_b_o
);

   localparam int NREG = 1 << SELW;

   logic [DW-1:0] regs [NREG];

   for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
      logic hit;
      assign hit = we_i && (wsel_i == SELW'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[gi] <= '0;
         end else if (hit) begin
            regs[gi] <= wdata_i;
         end
      end
   end

   assign rdata_a_o = regs[rsel_a_i];
   assign rdata_b_o = regs[rsel_b_i];

endmodule

// File: rtl/qrp_alu.sv
module qrp_alu
   import qrp_pkg::*;
#(
   parameter int DW           = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  alu_fn_e       fn_i,
   input  logic [DW-1:0] dst_val_i,
   input  logic [DW-1:0] src_val_i,
   input  logic [DW-1:0] mem_val_i,
   output logic [DW-1:0] res_o
);

   logic [DW-1:0] arith;
   logic          is_sub;

   assign is_sub = (fn_i == FN_SUB);

   if (SHARED_ADDER) begin : g_shared
      logic [DW-1:0] opnd_b;
      assign opnd_b = is_sub ? ~src_val_i : src_val_i;
      assign arith  = dst_val_i + opnd_b + {{(DW-1){1'b0}}, is_sub};
   end else begin : g_split
      logic [DW-1:0] sum;
      logic [DW-1:0] diff;
      assign sum   = dst_val_i + src_val_i;
      assign diff  = dst_val_i - src_val_i;
      assign arith = is_sub ? diff : sum;
   end

   always_comb begin
      case (fn_i)
         FN_MEMRD: res_o = mem_val_i;
         FN_COPY:  res_o = src_val_i;
         FN_INV:   res_o = ~src_val_i;
         FN_ADD,
         FN_SUB:   res_o = arith;
         default:  res_o = src_val_i;
      endcase
   end

endmodule

// File: rtl/qrp_pcgen.sv
module qrp_pcgen
   import qrp_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  pc_sel_e       sel_i,
   input  logic [AW-1:0] target_i,
   output logic [AW-1:0] pc_o
);

   logic [AW-1:0] pc_q;
   logic [AW-1:0] pc_d;

   always_comb begin
      case (sel_i)
         PCS_STEP1: pc_d = pc_q + AW'(1);
         PCS_STEP2: pc_d = pc_q + AW'(2);
         PCS_LOAD:  pc_d = target_i;
         default:   pc_d = pc_q + AW'(1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else begin
         pc_q <= pc_d;
      end
   end

   assign pc_o = pc_q;

endmodule

// File: rtl/qrp_core.sv
module qrp_core
   import qrp_pkg::*;
#(
   parameter int DW           = 8,
   parameter int AW           = 8,
   parameter int SELW         = 2,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      op_i,
   input  logic            mod_i,
   input  logic [SELW-1:0] dst_i,
   input  logic [SELW-1:0] src_i,
   input  logic [AW-1:0]   fld_i,
   input  logic            cond_i,
   input  logic [DW-1:0]   mem_rdata_i,
   output logic [AW-1:0]   mem_addr_o,
   output logic [DW-1:0]   mem_wdata_o,
   output logic            mem_we_o,
   output logic [AW-1:0]   pc_o
);

   if (DW < 2) begin : g_bad_dw
      $error("qrp_core: DW must be at least 2");
   end
   if (AW < 2) begin : g_bad_aw
      $error("qrp_core: AW must be at least 2 so the counter can step by two");
   end
   if (SELW < 1 || SELW > 4) begin : g_bad_selw
      $error("qrp_core: SELW must lie in 1..4");
   end

   ctrl_t         ctrl;
   logic [DW-1:0] dst_val;
   logic [DW-1:0] src_val;
   logic [DW-1:0] result;

   qrp_decode u_decode (
      .op_i   (op_i),
      .mod_i  (mod_i),
      .cond_i (cond_i),
      .ctrl_o (ctrl)
   );

   qrp_regfile #(.DW(DW), .SELW(SELW)) u_regfile (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (ctrl.rf_we),
      .wsel_i    (dst_i),
      .wdata_i   (result),
      .rsel_a_i  (dst_i),
      .rsel_b_i  (src_i),
      .rdata_a_o (dst_val),
      .rdata_b_o (src_val)
   );

   qrp_alu #(.DW(DW), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .fn_i      (ctrl.fn),
      .dst_val_i (dst_val),
      .src_val_i (src_val),
      .mem_val_i (mem_rdata_i),
      .res_o     (result)
   );

   qrp_pcgen #(.AW(AW)) u_pcgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_i    (ctrl.pc_sel),
      .target_i (fld_i),
      .pc_o     (pc_o)
   );

   assign mem_addr_o  = fld_i;
   assign mem_wdata_o = src_val;
   assign mem_we_o    = ctrl.mem_we;

endmodule

// File: rtl/qrp_core_chk.sv
module qrp_core_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    op_i,
   input logic          mod_i,
   input logic          cond_i,
   input logic [AW-1:0] fld_i,
   input logic          mem_we_o,
   input logic [AW-1:0] pc_o
);

   AST_RESET_PC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pc_o == '0)) else $error("pc not zero after reset"); // R7

   AST_STORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd0 && mod_i) |-> mem_we_o) else $error("store without strobe"); // R2

   AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_i == 2'd0 && mod_i) |-> !mem_we_o) else $error("strobe on non-store"); // R9

   AST_MEM_PC_STEP2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd0) |=> (pc_o == AW'($past(pc_o) + AW'(2)))) else $error("memory op step"); // R1

   AST_REG_PC_STEP1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd1 || op_i == 2'd2) |=> (pc_o == AW'($past(pc_o) + AW'(1)))) else $error("register op step"); // R3

   AST_JUMP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd3 && !mod_i) |=> (pc_o == $past(fld_i))) else $error("jump target"); // R5

   AST_CJUMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd3 && mod_i && cond_i) |=> (pc_o == $past(fld_i))) else $error("taken branch"); // R6

   AST_CJUMP_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd3 && mod_i && !cond_i) |=> (pc_o == AW'($past(pc_o) + AW'(2)))) else $error("untaken branch"); // R6

endmodule

bind qrp_core qrp_core_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_i     (op_i),
   .mod_i    (mod_i),
   .cond_i   (cond_i),
   .fld_i    (fld_i),
   .mem_we_o (mem_we_o),
   .pc_o     (pc_o)
);

// File: tb/qrp_core_bench.sv
`timescale 1ns/1ps
module qrp_core_bench;

   localparam real HALF = 2.5;

   typedef struct {
      logic [7:0] pc;
      logic       we;
      logic [7:0] wd;
      logic [7:0] addr;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] op = 2'd3;
   logic       mb = 1'b0;
   logic [1:0] dst = '0;
   logic [1:0] src = '0;
   logic [7:0] fld = '0;
   logic       cond = 1'b0;
   logic [7:0] mem_rdata;
   logic [7:0] mem_addr;
   logic [7:0] mem_wdata;
   logic       mem_we;
   logic [7:0] pc;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   exp_t       q [$];
   logic [7:0] m_reg [4];
   logic [7:0] m_pc;

   always #(HALF) clk = ~clk;

   function automatic logic [7:0] mem_fn(logic [7:0] a);
      logic [7:0] r;
      r = (a * 8'd37) + 8'd11;
      return r;
   endfunction

   assign mem_rdata = mem_fn(mem_addr);

   qrp_core u_qrp_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_i        (op),
      .mod_i       (mb),
      .dst_i       (dst),
      .src_i       (src),
      .fld_i       (fld),
      .cond_i      (cond),
      .mem_rdata_i (mem_rdata),
      .mem_addr_o  (mem_addr),
      .mem_wdata_o (mem_wdata),
      .mem_we_o    (mem_we),
      .pc_o        (pc)
   );

   task automatic check8(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // driver: applies one instruction and pushes the expected outcome
   task automatic issue(logic [1:0] o, logic b, logic [1:0] d, logic [1:0] s,
                        logic [7:0] a, logic c, string tag);
      exp_t e;
      @(negedge clk);
      op = o; mb = b; dst = d; src = s; fld = a; cond = c;
      e.we = 1'b0; e.wd = '0; e.addr = a; e.tag = tag;
      case (o)
         2'd0: begin
            if (!b) m_reg[d] = mem_fn(a);
            else begin e.we = 1'b1; e.wd = m_reg[s]; end
            m_pc = m_pc + 8'd2;
         end
         2'd1: begin
            m_reg[d] = b ? ~m_reg[s] : m_reg[s];
            m_pc = m_pc + 8'd1;
         end
         2'd2: begin
            m_reg[d] = b ? (m_reg[d] - m_reg[s]) : (m_reg[d] + m_reg[s]);
            m_pc = m_pc + 8'd1;
         end
         default: begin
            if (!b || c) m_pc = a;
            else m_pc = m_pc + 8'd2;
         end
      endcase
      e.pc = m_pc;
      q.push_back(e);
   endtask

   task automatic store(logic [1:0] s, logic [7:0] a, string tag);
      issue(2'd0, 1'b1, 2'd0, s, a, 1'b0, tag);
   endtask

   // monitor: compares each executed instruction with its expected item
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check8(e.tag, "pc", pc, e.pc);
            checks++;
            if (mem_we !== e.we) begin
               failures++;
               $display("FAIL %s mem_we actual=%0b expected=%0b", e.tag, mem_we, e.we);
            end
            if (e.we) begin
               check8(e.tag, "wdata", mem_wdata, e.wd);
               check8(e.tag, "addr", mem_addr, e.addr);
            end
         end
      end
   end

   initial begin
      #(200000 * 2 * HALF);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) m_reg[i] = '0;
      m_pc = '0;
      repeat (3) @(posedge clk);
      #1;
      check8("R7", "pc in reset", pc, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;          // idle instruction is jump to 0: model stays at 0
      @(posedge clk);
      #1;
      check8("R7", "pc after release", pc, 8'h00);

      // R7: all registers read back zero
      for (int i = 0; i < 4; i++) store(2'(i), 8'h10 + 8'(i), "R7");

      // R1: loads into every register
      issue(2'd0, 1'b0, 2'd0, 2'd0, 8'h03, 1'b0, "R1");
      issue(2'd0, 1'b0, 2'd1, 2'd0, 8'h40, 1'b0, "R1");
      issue(2'd0, 1'b0, 2'd2, 2'd0, 8'h7F, 1'b0, "R1");
      issue(2'd0, 1'b0, 2'd3, 2'd0, 8'hC2, 1'b0, "R1");
      for (int i = 0; i < 4; i++) store(2'(i), 8'hA0 + 8'(i), "R2");

      // R3: copy and complement
      issue(2'd1, 1'b0, 2'd2, 2'd0, 8'h00, 1'b0, "R3");
      store(2'd2, 8'h21, "R3");
      issue(2'd1, 1'b1, 2'd1, 2'd3, 8'h00, 1'b0, "R3");
      store(2'd1, 8'h22, "R3");

      // R4: add reaches 0xFF then wraps; subtract borrows
      issue(2'd2, 1'b0, 2'd3, 2'd1, 8'h00, 1'b0, "R4");
      store(2'd3, 8'h30, "R4");
      issue(2'd2, 1'b0, 2'd3, 2'd0, 8'h00, 1'b0, "R4");
      store(2'd3, 8'h31, "R4");
      issue(2'd2, 1'b1, 2'd0, 2'd1, 8'h00, 1'b0, "R4");
      store(2'd0, 8'h32, "R4");

      // R8: same-register operands and the 3 <- 3 + 2 case
      issue(2'd2, 1'b0, 2'd2, 2'd2, 8'h00, 1'b0, "R8");
      store(2'd2, 8'h40, "R8");
      issue(2'd2, 1'b1, 2'd1, 2'd1, 8'h00, 1'b0, "R8");
      store(2'd1, 8'h41, "R8");
      issue(2'd2, 1'b0, 2'd3, 2'd2, 8'h00, 1'b0, "R8");
      store(2'd3, 8'h42, "R8");

      // R5 / R6: jumps
      issue(2'd3, 1'b0, 2'd0, 2'd0, 8'h80, 1'b0, "R5");
      issue(2'd3, 1'b1, 2'd0, 2'd0, 8'h20, 1'b1, "R6");
      issue(2'd3, 1'b1, 2'd0, 2'd0, 8'h99, 1'b0, "R6");
      issue(2'd3, 1'b0, 2'd0, 2'd0, 8'h5C, 1'b1, "R5");

      // R9: counter wraps on both step sizes
      issue(2'd3, 1'b0, 2'd0, 2'd0, 8'hFF, 1'b0, "R9");
      issue(2'd1, 1'b0, 2'd0, 2'd0, 8'h00, 1'b0, "R9");
      issue(2'd3, 1'b0, 2'd0, 2'd0, 8'hFE, 1'b0, "R9");
      store(2'd0, 8'h55, "R9");

      @(posedge clk);
      #2;
      done = 1'b1;
      if (q.size() != 0) begin
         failures++;
         $display("FAIL scoreboard left=%0d expected=0", q.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule